// File: doc/BRIEF.md
# Auto-Increment Register Bank with Indirect Pair Table

This block is an eight-entry byte register bank placed behind a simple transaction interface. A host opens a transaction with a start pulse, streams bytes in over a valid/ready channel and closes it with an end pulse. Bytes are held in a small receive buffer and applied only when the transaction closes. The first byte of a transaction always loads the register pointer. Any further bytes are written to consecutive registers, and the pointer wraps after the last register. A transaction that carries only one byte therefore just positions the pointer for a later read.

Reads are single-byte requests. Each request returns the byte at the pointer on a valid/ready response channel and then advances the pointer. Two of the registers are windows onto an internal table of coarse/fine byte pairs. The pair is selected by the table-address register, and it is stored in the table only when its fine byte is written.

Writes to the timer-setting registers raise a one-cycle reinitialise strobe. Writes to the PWM registers raise a one-cycle update strobe.

Back-pressure rules:
- `in_ready` is low while a closed transaction is being applied or while a read response waits to be taken.
- A byte transfers only on a cycle where `in_valid` and `in_ready` are both high.
- `rd_req` is acted on only in a cycle where `in_ready` is high.
- `rsp_data` holds steady while `rsp_valid` is high and `rsp_ready` is low.
- `txn_start` must come before the first byte of a transaction.

Top module: `regbank_top`

## Requirements
- R1: After reset, registers 0..7 hold 4, 123, 8, 127, 254, 0, 0, 0, and every table byte is 0.
- R2: A transaction with exactly one byte writes nothing. It only loads the pointer with the low 3 bits of that byte.
- R3: In a longer transaction, the first byte loads the pointer. Each later byte is written to the register at the pointer, after which the pointer advances, and it goes from 7 back to 0.
- R4: Each accepted read returns the byte at the pointer and then advances the pointer, with the same 7-to-0 wrap.
- R5: A read of index 6 returns table byte 2·A. A read of index 7 returns table byte 2·A+1. A is register 5. Reads of any other index return the register itself.
- R6: A write to index 7 stores the current register 6 and the new byte into table bytes 2·A and 2·A+1. A write to index 6 on its own leaves the table unchanged.
- R7: Register 5 keeps only the low 7 bits of a written byte, so A is always in the range 0..127.
- R8: Each write to index 0, 1 or 2 gives one `tmr_reinit` pulse, and each write to index 3 or 4 gives one `pwm_update` pulse. Each pulse comes in the cycle after the write. Writes to 5, 6 or 7 give no pulse.
- R9: A transaction with no bytes, or with more bytes than RX_DEPTH, is discarded. It writes no register, raises no strobe and leaves the pointer where it was.
- R10: `in_ready` is low whenever `rsp_valid` is high. A pending response keeps `rsp_valid` high and `rsp_data` unchanged until `rsp_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | One-cycle pulse that opens a transaction and empties the receive buffer |
| txn_end | input | 1 | One-cycle pulse that closes the transaction and applies it |
| in_valid | input | 1 | Incoming byte valid |
| in_ready | output | 1 | Block can accept a byte or a read request |
| in_data | input | 8 | Incoming byte |
| rd_req | input | 1 | Single-byte read request, acted on while in_ready is high |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the read response |
| rsp_data | output | 8 | Read response byte |
| tmr_reinit | output | 1 | One-cycle strobe after a write to index 0..2 |
| pwm_update | output | 1 | One-cycle strobe after a write to index 3..4 |

## Verification
The bench builds the block with RX_DEPTH set to 8 and TBL_PAIRS left at 128. The small receive depth means a nine-byte transaction is enough to reach the over-depth discard case. The full table range keeps the masking of table address 200 down to 72 observable, and it lets table entries 3 and 42 be written and read back independently.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DW   = 8;
  localparam int NREG = 8;
  localparam int PW   = $clog2(NREG);

  typedef enum logic [PW-1:0] {
    IX_PRESC = 3'd0,
    IX_CRS   = 3'd1,
    IX_FIN   = 3'd2,
    IX_DUTY  = 3'd3,
    IX_PER   = 3'd4,
    IX_TADDR = 3'd5,
    IX_TCRS  = 3'd6,
    IX_TFIN  = 3'd7
  } reg_ix_e;

  typedef enum logic {ST_IDLE, ST_DRAIN} seq_e;

  function automatic logic [DW-1:0] reset_val(input int idx);
    case (idx)
      0:       return 8'd4;
      1:       return 8'd123;
      2:       return 8'd8;
      3:       return 8'd127;
      4:       return 8'd254;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (int'(p) == NREG - 1) ? '0 : p + 1'b1;
  endfunction
endpackage

// File: rtl/regbank_rxbuf.sv
module regbank_rxbuf
  import regbank_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic [IW-1:0] rd_idx,
  output logic [CW-1:0] cnt,
  output logic          ovf,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] mem [DEPTH];
  logic          full;

  assign full = (cnt == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (push) begin
      if (full) ovf <= 1'b1;
      else      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr && !full) mem[cnt[IW-1:0]] <= din;
  end

  assign dout = mem[rd_idx];
endmodule

// File: rtl/regbank_regs.sv
module regbank_regs
  import regbank_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_ptr,
  input  logic [PW-1:0] ptr_in,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [PW-1:0] ptr,
  output logic [AW-1:0] taddr,
  output logic [DW-1:0] tcrs,
  output logic [DW-1:0] reg_rd,
  output logic          tbl_commit,
  output logic          tmr_stb,
  output logic          pwm_stb
);
  logic [DW-1:0] r [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == int'(IX_TADDR)) begin : g_mask
      always_ff @(posedge clk) begin
        if (!rst_n)                           r[g] <= reset_val(g);
        else if (wr_en && ptr == PW'(g))      r[g] <= {{(DW-AW){1'b0}}, wr_data[AW-1:0]};
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)                           r[g] <= reset_val(g);
        else if (wr_en && ptr == PW'(g))      r[g] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                ptr <= '0;
    else if (ld_ptr)           ptr <= ptr_in;
    else if (wr_en || rd_en)   ptr <= ptr_next(ptr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_stb <= 1'b0;
      pwm_stb <= 1'b0;
    end else begin
      tmr_stb <= wr_en && (ptr inside {IX_PRESC, IX_CRS, IX_FIN});
      pwm_stb <= wr_en && (ptr inside {IX_DUTY, IX_PER});
    end
  end

  assign tbl_commit = wr_en && (ptr == IX_TFIN);
  assign taddr      = r[IX_TADDR][AW-1:0];
  assign tcrs       = r[IX_TCRS];
  assign reg_rd     = r[ptr];
endmodule

// File: rtl/regbank_table.sv
module regbank_table
  import regbank_pkg::*;
#(
  parameter int PAIRS = 128,
  localparam int AW = $clog2(PAIRS),
  localparam int NB = 2 * PAIRS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] lo_byte,
  input  logic [DW-1:0] hi_byte,
  input  logic          rd_hi,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [NB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) mem[i] <= '0;
    end else if (commit) begin
      mem[{addr, 1'b0}] <= lo_byte;
      mem[{addr, 1'b1}] <= hi_byte;
    end
  end

  assign rd_data = mem[{addr, rd_hi}];
endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
#(
  parameter int RX_DEPTH  = 16,
  parameter int TBL_PAIRS = 128,
  localparam int CW = $clog2(RX_DEPTH + 1),
  localparam int IW = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1,
  localparam int AW = $clog2(TBL_PAIRS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txn_start,
  input  logic       txn_end,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       rd_req,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data,
  output logic       tmr_reinit,
  output logic       pwm_update
);
  seq_e          state;
  logic [IW-1:0] idx;
  logic [CW-1:0] rx_cnt;
  logic          rx_ovf;
  logic [DW-1:0] rx_byte;
  logic          rx_clr, rx_push;
  logic          busy, last, drop, rd_fire;
  logic          ld_ptr, wr_en;
  logic [PW-1:0] ptr;
  logic [AW-1:0] taddr;
  logic [DW-1:0] tcrs, reg_rd, tbl_rd, rd_mux;
  logic          tbl_commit, tmr_stb, pwm_stb;

  assign busy     = (state == ST_DRAIN);
  assign in_ready = !busy && !rsp_valid;
  assign rx_push  = in_valid && in_ready;
  assign rd_fire  = rd_req && in_ready;
  assign last     = busy && (CW'(idx) == rx_cnt - 1'b1);
  assign drop     = !busy && txn_end && (rx_cnt == '0 || rx_ovf);
  assign rx_clr   = txn_start || last || drop;
  assign ld_ptr   = busy && (idx == '0);
  assign wr_en    = busy && (idx != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (txn_end && !drop) begin
          state <= ST_DRAIN;
          idx   <= '0;
        end
        ST_DRAIN: begin
          idx <= idx + 1'b1;
          if (last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  regbank_rxbuf #(.DEPTH(RX_DEPTH)) u_rxbuf (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .din(in_data),
    .rd_idx(idx), .cnt(rx_cnt), .ovf(rx_ovf), .dout(rx_byte)
  );

  regbank_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .ld_ptr(ld_ptr), .ptr_in(rx_byte[PW-1:0]),
    .wr_en(wr_en), .wr_data(rx_byte), .rd_en(rd_fire), .ptr(ptr),
    .taddr(taddr), .tcrs(tcrs), .reg_rd(reg_rd), .tbl_commit(tbl_commit),
    .tmr_stb(tmr_stb), .pwm_stb(pwm_stb)
  );

  regbank_table #(.PAIRS(TBL_PAIRS)) u_table (
    .clk(clk), .rst_n(rst_n), .commit(tbl_commit), .addr(taddr),
    .lo_byte(tcrs), .hi_byte(rx_byte), .rd_hi(ptr == IX_TFIN),
    .rd_data(tbl_rd)
  );

  assign rd_mux = (ptr inside {IX_TCRS, IX_TFIN}) ? tbl_rd : reg_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_mux;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign tmr_reinit = tmr_stb;
  assign pwm_update = pwm_stb;
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       rd_req,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       tmr_reinit,
  input logic       pwm_update,
  input logic       busy,
  input logic       txn_end,
  input logic       rx_ovf
);
  p_no_ready_while_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !in_ready);

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_rsp_after_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rsp_valid && !busy) |=> rsp_valid);

  p_strobe_from_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_reinit || pwm_update) |-> $past(busy));

  p_strobe_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(tmr_reinit && pwm_update));

  p_overflow_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_end && rx_ovf && !busy) |=> !busy);
endmodule

bind regbank_top regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .rd_req(rd_req),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .tmr_reinit(tmr_reinit), .pwm_update(pwm_update), .busy(busy),
  .txn_end(txn_end), .rx_ovf(rx_ovf)
);

// File: tb/tb_regbank_top.sv
module tb_regbank_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  // vector: {is_read, index, write data, expected read}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b1, 8'd0, 8'd0,   8'd4},
    {1'b1, 8'd1, 8'd0,   8'd123},
    {1'b1, 8'd2, 8'd0,   8'd8},
    {1'b1, 8'd3, 8'd0,   8'd127},
    {1'b1, 8'd4, 8'd0,   8'd254},
    {1'b1, 8'd5, 8'd0,   8'd0},
    {1'b1, 8'd6, 8'd0,   8'd0},
    {1'b1, 8'd7, 8'd0,   8'd0},
    {1'b0, 8'd3, 8'd55,  8'd0},
    {1'b1, 8'd3, 8'd0,   8'd55},
    {1'b0, 8'd5, 8'd200, 8'd0},
    {1'b1, 8'd5, 8'd0,   8'd72},
    {1'b0, 8'd0, 8'd2,   8'd0},
    {1'b1, 8'd0, 8'd0,   8'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txn_start = 1'b0, txn_end = 1'b0, in_valid = 1'b0, rd_req = 1'b0, rsp_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, rsp_valid, tmr_reinit, pwm_update;
  logic [7:0] rsp_data;
  int n_chk = 0, n_bad = 0, n_tmr = 0, n_pwm = 0;
  logic [7:0] tx [16];
  logic [7:0] got;

  always #(CLK_PERIOD / 2) clk = ~clk;

  regbank_top #(.RX_DEPTH(8), .TBL_PAIRS(128)) dut (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_end(txn_end),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .rd_req(rd_req), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .tmr_reinit(tmr_reinit), .pwm_update(pwm_update)
  );

  always @(posedge clk) begin
    if (rst_n && tmr_reinit) n_tmr <= n_tmr + 1;
    if (rst_n && pwm_update) n_pwm <= n_pwm + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input int n);
    @(negedge clk) txn_start = 1'b1;
    @(negedge clk) txn_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_data = tx[i];
      @(negedge clk);
      in_valid = 1'b0;
    end
    txn_end = 1'b1;
    @(negedge clk) txn_end = 1'b0;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr1(input logic [7:0] ix, input logic [7:0] d);
    tx[0] = ix; tx[1] = d; send(2);
  endtask

  task automatic setp(input logic [7:0] ix);
    tx[0] = ix; send(1);
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk) rd_req = 1'b0;
    d = rsp_data;
    rsp_ready = 1'b1;
    @(negedge clk) rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int t0, p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 in_ready after reset", int'(in_ready), 1);
    chk("R10 rsp_valid after reset", int'(rsp_valid), 0);

    // vector walk: R1 reset values, R7 address mask
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][24]) begin
        setp(VEC[i][23:16]);
        rd(got);
        chk($sformatf("R1/R7 vector %0d", i), int'(got), int'(VEC[i][7:0]));
      end else begin
        wr1(VEC[i][23:16], VEC[i][15:8]);
      end
    end

    // R3 burst with table commit, pointer wraps to 0
    tx[0] = 8'd5; tx[1] = 8'd42; tx[2] = 8'd127; tx[3] = 8'd64; send(4);
    rd(got); chk("R3 wrap 7->0 after burst", int'(got), 2);

    // R5 / R4 readback through windows, then wrap
    setp(8'd6);
    rd(got); chk("R5 table lo", int'(got), 127);
    rd(got); chk("R5 table hi (R4 increment)", int'(got), 64);
    rd(got); chk("R4 read wrap to 0", int'(got), 2);

    // R6 index 6 alone does not commit
    wr1(8'd6, 8'd9);
    setp(8'd6); rd(got); chk("R6 no commit on index 6", int'(got), 127);
    wr1(8'd7, 8'd77);
    setp(8'd6);
    rd(got); chk("R6 commit lo", int'(got), 9);
    rd(got); chk("R6 commit hi", int'(got), 77);

    // R5 second entry distinct
    tx[0] = 8'd5; tx[1] = 8'd3; tx[2] = 8'd11; tx[3] = 8'd22; send(4);
    setp(8'd6); rd(got); chk("R5 entry 3 lo", int'(got), 11);
    rd(got); chk("R5 entry 3 hi", int'(got), 22);
    wr1(8'd5, 8'd42);
    setp(8'd6); rd(got); chk("R5 entry 42 kept", int'(got), 9);

    // R2 single byte only positions pointer
    setp(8'd3); rd(got); chk("R2 single byte no write", int'(got), 55);
    setp(8'd12); rd(got); chk("R2 pointer low 3 bits", int'(got), 254);

    // R9 empty transaction: pointer at 5 stays
    t0 = n_tmr;
    send(0);
    rd(got); chk("R9 empty txn ignored", int'(got), 42);

    // R9 over-depth: pointer at 6 stays, reg 0 untouched
    tx[0] = 8'd0;
    for (int i = 1; i < 9; i++) tx[i] = 8'd99;
    send(9);
    chk("R9 overflow no strobe", n_tmr, t0);
    rd(got); chk("R9 overflow pointer kept", int'(got), 9);
    setp(8'd0); rd(got); chk("R9 overflow no write", int'(got), 2);

    // R8 strobes
    t0 = n_tmr; p0 = n_pwm;
    tx[0] = 8'd1; tx[1] = 8'd10; tx[2] = 8'd20; tx[3] = 8'd30; tx[4] = 8'd40; send(5);
    chk("R8 timer strobes", n_tmr - t0, 2);
    chk("R8 pwm strobes", n_pwm - p0, 2);
    wr1(8'd6, 8'd5);
    chk("R8 no timer strobe idx6", n_tmr - t0, 2);
    chk("R8 no pwm strobe idx6", n_pwm - p0, 2);
    setp(8'd1); rd(got); chk("R3 burst first reg", int'(got), 10);
    rd(got); chk("R3 burst next reg", int'(got), 20);

    // R10 response held under back-pressure
    setp(8'd4);
    @(negedge clk) rd_req = 1'b1;
    @(negedge clk) rd_req = 1'b0;
    got = rsp_data;
    repeat (3) @(negedge clk);
    chk("R10 rsp_valid held", int'(rsp_valid), 1);
    chk("R10 rsp_data stable", int'(rsp_data), int'(got));
    chk("R10 in_ready low while pending", int'(in_ready), 0);
    chk("R10 held data value", int'(rsp_data), 40);
    rsp_ready = 1'b1;
    @(negedge clk) rsp_ready = 1'b0;
    chk("R10 rsp_valid cleared", int'(rsp_valid), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule